// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Error Tracking

This block sits between the bit deserializer of a serial receiver and the CPU. Every assembled character is stored in a small queue together with two flags: one for a parity fault and one for an overrun. The oldest stored character is the head. Software sees the head byte on a data port. It also sees a status view that combines the head's flags with sticky copies of every fault seen since the last error-reset strobe. Because reading the data port advances the queue, software reads the status first and then the data. This keeps each set of flags matched to its character.

A character whose flags need attention raises a special-receive-condition request when it reaches the head. In first-character-only mode, such a character freezes the receive side. The CPU can still inspect the character, but reads do not remove it, and no later character becomes available. Only the error-reset strobe ends the freeze, and it discards the held character. At the end of a line break, the deserializer signals the block, and one all-zero character is queued.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the buffer is empty: `rx_avail_o`, `src_req_o`, both status bits and `data_o` are 0.
- R2: Characters leave in arrival order. `data_o` shows the head character, or 0 when empty. Up to `SLOTS` (default 4) characters are held.
- R3: A character that arrives while all `SLOTS` entries are full and no read happens in that cycle replaces the newest entry, and that entry's overrun flag is set. Older entries are unchanged.
- R4: `stat_parity_o` and `stat_overrun_o` include the head character's own flags. After a read, the next character's flags appear.
- R5: Once a status bit is 1, it stays 1 until `err_reset_i` is pulsed. After the pulse it shows only the flags of the current head.
- R6: `src_req_o` is 1 while a head character is present whose overrun flag is set, or whose parity flag is set while `par_chk_en_i` is 1. A parity flag alone raises no request while `par_chk_en_i` is 0.
- R7: While `first_only_i` is 1 and the head raises a request, a hold is active. During the hold, `rd_data_i` does not remove the head and `data_o` stays stable. The hold lasts until `err_reset_i`, which discards the held character and releases the hold.
- R8: During a hold, arriving characters are still stored. After release they become available in arrival order.
- R9: A pulse on `brk_end_i` queues one character 0x00 with both flags clear. `rx_valid_i` is ignored in that cycle.
- R10: `rx_avail_o` is 1 exactly when the head holds a character and no hold is active.
- R11: `rd_data_i` on an empty buffer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a character has been assembled |
| rx_data_i | input | CHAR_W | Assembled character |
| rx_par_err_i | input | 1 | Parity fault on the assembled character |
| brk_end_i | input | 1 | One-cycle strobe: a break has ended; queue 0x00 |
| par_chk_en_i | input | 1 | Parity faults count toward the request |
| first_only_i | input | 1 | First-character-only mode, freezes on a fault |
| rd_data_i | input | 1 | One-cycle CPU read of the head character |
| err_reset_i | input | 1 | One-cycle error-reset command |
| data_o | output | CHAR_W | Head character |
| rx_avail_o | output | 1 | Head character readable |
| stat_parity_o | output | 1 | Parity status (head plus sticky) |
| stat_overrun_o | output | 1 | Overrun status (head plus sticky) |
| src_req_o | output | 1 | Special receive condition request |

## Verification
The assertions check on every cycle that:
- the status bits stay set until an error reset;
- a request is always backed by a visible flag;
- availability is never shown during a hold;
- the head byte does not move while frozen.

Only the bench scenarios can show the following:
- arrival order;
- which entry an overrun replaces;
- the flags of the next character appearing after a read;
- the all-zero break character;
- the held character being discarded and later ones surfacing after release.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par;
    logic              ovr;
  } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  rxf_entry_t push_ent_i,
  input  logic       pop_i,
  output rxf_entry_t head_o,
  output logic       nonempty_o
);
  localparam int unsigned PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned CW = $clog2(SLOTS + 1);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);
  localparam logic [CW-1:0] FULL = CW'(SLOTS);

  rxf_entry_t    mem_q [SLOTS];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q, newest;
  logic [CW-1:0] cnt_q;
  logic          pop_fire, push_norm, push_ovr;
  rxf_entry_t    wr_ent;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign pop_fire  = pop_i && (cnt_q != '0);
  assign push_norm = push_i && ((cnt_q != FULL) || pop_fire);
  assign push_ovr  = push_i && (cnt_q == FULL) && !pop_fire;
  assign newest    = (wr_ptr_q == '0) ? LAST : wr_ptr_q - 1'b1;

  always_comb begin
    wr_ent     = push_ent_i;
    wr_ent.ovr = push_ent_i.ovr | push_ovr;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic we;
    assign we = (push_norm && wr_ptr_q == PW'(i)) || (push_ovr && newest == PW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[i] <= '0;
      else if (we)  mem_q[i] <= wr_ent;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (pop_fire)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_norm) wr_ptr_q <= ptr_inc(wr_ptr_q);
      case ({push_norm, pop_fire})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign nonempty_o = (cnt_q != '0);
  assign head_o     = mem_q[rd_ptr_q];
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  rxf_entry_t head_i,
  input  logic       nonempty_i,
  input  logic       err_reset_i,
  input  logic       par_chk_en_i,
  output logic       stat_par_o,
  output logic       stat_ovr_o,
  output logic       src_o
);
  logic sticky_par_q, sticky_ovr_q;
  logic head_par, head_ovr;

  assign head_par = nonempty_i && head_i.par;
  assign head_ovr = nonempty_i && head_i.ovr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_par_q <= 1'b0;
      sticky_ovr_q <= 1'b0;
    end else if (err_reset_i) begin
      sticky_par_q <= 1'b0;
      sticky_ovr_q <= 1'b0;
    end else begin
      sticky_par_q <= sticky_par_q | head_par;
      sticky_ovr_q <= sticky_ovr_q | head_ovr;
    end
  end

  assign stat_par_o = sticky_par_q | head_par;
  assign stat_ovr_o = sticky_ovr_q | head_ovr;
  assign src_o      = head_ovr | (head_par & par_chk_en_i);
endmodule

// File: rtl/rxf_hold.sv
module rxf_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic first_only_i,
  input  logic src_i,
  input  logic err_reset_i,
  output logic hold_o
);
  logic hold_q, trig;

  assign trig = first_only_i && src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hold_q <= 1'b0;
    else if (err_reset_i) hold_q <= 1'b0;
    else if (trig)        hold_q <= 1'b1;
  end

  // trig covers the cycle a faulty character first reaches the head
  assign hold_o = hold_q | trig;
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_par_err_i,
  input  logic              brk_end_i,
  input  logic              par_chk_en_i,
  input  logic              first_only_i,
  input  logic              rd_data_i,
  input  logic              err_reset_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              rx_avail_o,
  output logic              stat_parity_o,
  output logic              stat_overrun_o,
  output logic              src_req_o
);
  rxf_entry_t push_ent, head;
  logic       push, pop, nonempty, hold, src;

  assign push = rx_valid_i | brk_end_i;

  always_comb begin
    push_ent = '0;
    if (!brk_end_i) begin
      push_ent.data = rx_data_i;
      push_ent.par  = rx_par_err_i;
    end
  end

  // a read only pops when no hold; an error reset discards a held head
  assign pop = hold ? err_reset_i : rd_data_i;

  rxf_store #(.SLOTS(SLOTS)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_ent_i (push_ent),
    .pop_i      (pop),
    .head_o     (head),
    .nonempty_o (nonempty)
  );

  rxf_status i_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_i       (head),
    .nonempty_i   (nonempty),
    .err_reset_i  (err_reset_i),
    .par_chk_en_i (par_chk_en_i),
    .stat_par_o   (stat_parity_o),
    .stat_ovr_o   (stat_overrun_o),
    .src_o        (src)
  );

  rxf_hold i_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .first_only_i (first_only_i),
    .src_i        (src),
    .err_reset_i  (err_reset_i),
    .hold_o       (hold)
  );

  assign src_req_o  = src;
  assign rx_avail_o = nonempty && !hold;
  assign data_o     = nonempty ? head.data : '0;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk
  import rxf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              par_chk_en_i,
  input logic              first_only_i,
  input logic              err_reset_i,
  input logic [CHAR_W-1:0] data_o,
  input logic              rx_avail_o,
  input logic              stat_parity_o,
  input logic              stat_overrun_o,
  input logic              src_req_o
);
  a_r5_parity_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_parity_o && !err_reset_i) |=> stat_parity_o);

  a_r5_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_overrun_o && !err_reset_i) |=> stat_overrun_o);

  a_r6_req_backed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_req_o |-> (stat_overrun_o || (stat_parity_o && par_chk_en_i)));

  a_r10_no_avail_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_only_i && src_req_o) |-> !rx_avail_o);

  a_r7_head_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_only_i && src_req_o && !err_reset_i) |=> $stable(data_o));
endmodule

bind rx_err_fifo rx_err_fifo_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .par_chk_en_i   (par_chk_en_i),
  .first_only_i   (first_only_i),
  .err_reset_i    (err_reset_i),
  .data_o         (data_o),
  .rx_avail_o     (rx_avail_o),
  .stat_parity_o  (stat_parity_o),
  .stat_overrun_o (stat_overrun_o),
  .src_req_o      (src_req_o)
);

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_par_err_i = 1'b0;
  logic       brk_end_i = 1'b0;
  logic       par_chk_en_i = 1'b1;
  logic       first_only_i = 1'b0;
  logic       rd_data_i = 1'b0;
  logic       err_reset_i = 1'b0;
  logic [7:0] data_o;
  logic       rx_avail_o, stat_parity_o, stat_overrun_o, src_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rx_err_fifo i_rx_err_fifo (.*);

  // {valid, brk, par, rd, ers, din, exp_data, exp_avail, exp_spar, exp_sovr, exp_src}
  localparam int NV = 19;
  localparam logic [24:0] VEC [NV] = '{
    {5'b10000, 8'hA1, 8'hA1, 4'b1000},
    {5'b10100, 8'hB2, 8'hA1, 4'b1000},
    {5'b10000, 8'hC3, 8'hA1, 4'b1000},
    {5'b00010, 8'h00, 8'hB2, 4'b1101},  // R4 parity of next head
    {5'b00010, 8'h00, 8'hC3, 4'b1100},  // R5 sticky
    {5'b00001, 8'h00, 8'hC3, 4'b1000},  // R5 cleared
    {5'b00010, 8'h00, 8'h00, 4'b0000},
    {5'b11100, 8'h55, 8'h00, 4'b1000},  // R9 break wins
    {5'b10000, 8'hD4, 8'h00, 4'b1000},
    {5'b10000, 8'hE5, 8'h00, 4'b1000},
    {5'b10000, 8'hF6, 8'h00, 4'b1000},
    {5'b10000, 8'h77, 8'h00, 4'b1000},  // R3 replaces F6
    {5'b00010, 8'h00, 8'hD4, 4'b1000},
    {5'b00010, 8'h00, 8'hE5, 4'b1000},
    {5'b00010, 8'h00, 8'h77, 4'b1011},
    {5'b10010, 8'h88, 8'h88, 4'b1010},
    {5'b00001, 8'h00, 8'h88, 4'b1000},
    {5'b00010, 8'h00, 8'h00, 4'b0000},
    {5'b00010, 8'h00, 8'h00, 4'b0000}   // R11 read on empty
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic p, input logic rd,
                      input logic er, input logic [7:0] d);
    rx_valid_i = v; brk_end_i = b; rx_par_err_i = p;
    rd_data_i = rd; err_reset_i = er; rx_data_i = d;
    @(negedge clk_i);
    rx_valid_i = 0; brk_end_i = 0; rx_par_err_i = 0;
    rd_data_i = 0; err_reset_i = 0; rx_data_i = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 data", data_o, 8'h00);
    chk("R1 avail", {7'b0, rx_avail_o}, 8'h00);
    chk("R1 status", {6'b0, stat_parity_o, stat_overrun_o}, 8'h00);
    chk("R1 src", {7'b0, src_req_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12]);
      chk($sformatf("R2 vec%0d data", i), data_o, VEC[i][11:4]);
      chk($sformatf("R10 vec%0d avail", i), {7'b0, rx_avail_o}, {7'b0, VEC[i][3]});
      chk($sformatf("R4 vec%0d spar", i), {7'b0, stat_parity_o}, {7'b0, VEC[i][2]});
      chk($sformatf("R3 vec%0d sovr", i), {7'b0, stat_overrun_o}, {7'b0, VEC[i][1]});
      chk($sformatf("R6 vec%0d src", i), {7'b0, src_req_o}, {7'b0, VEC[i][0]});
    end

    // R5: sticky survives the read of the faulty character
    step(1, 0, 1, 0, 0, 8'h11);
    step(0, 0, 0, 1, 0, 8'h00);
    chk("R5 sticky after read", {7'b0, stat_parity_o}, 8'h01);
    chk("R11 empty avail", {7'b0, rx_avail_o}, 8'h00);
    step(0, 0, 0, 0, 1, 8'h00);
    chk("R5 cleared", {7'b0, stat_parity_o}, 8'h00);

    // R6: parity alone requests only when checking is enabled
    par_chk_en_i = 1'b0;
    step(1, 0, 1, 0, 0, 8'h22);
    chk("R6 parity ignored", {7'b0, src_req_o}, 8'h00);
    par_chk_en_i = 1'b1;
    #1;
    chk("R6 parity counted", {7'b0, src_req_o}, 8'h01);
    step(0, 0, 0, 1, 0, 8'h00);
    step(0, 0, 0, 0, 1, 8'h00);

    // R9: break end queues a clean zero
    step(1, 1, 1, 0, 0, 8'hAA);
    chk("R9 zero char", data_o, 8'h00);
    chk("R9 clean flags", {6'b0, stat_parity_o, stat_overrun_o}, 8'h00);
    chk("R9 avail", {7'b0, rx_avail_o}, 8'h01);
    step(0, 0, 0, 1, 0, 8'h00);

    // R7 / R8: first-character-only freeze
    first_only_i = 1'b1;
    step(1, 0, 0, 0, 0, 8'h33);
    chk("R10 clean head avail", {7'b0, rx_avail_o}, 8'h01);
    step(1, 0, 1, 0, 0, 8'h44);
    step(0, 0, 0, 1, 0, 8'h00);
    chk("R7 held data", data_o, 8'h44);
    chk("R7 no avail", {7'b0, rx_avail_o}, 8'h00);
    chk("R7 request", {7'b0, src_req_o}, 8'h01);
    step(0, 0, 0, 1, 0, 8'h00);
    chk("R7 read does not pop", data_o, 8'h44);
    step(1, 0, 0, 0, 0, 8'h55);
    chk("R8 still frozen", {7'b0, rx_avail_o}, 8'h00);
    chk("R8 head unchanged", data_o, 8'h44);
    step(0, 0, 0, 0, 1, 8'h00);
    chk("R7 released data", data_o, 8'h55);
    chk("R7 released avail", {7'b0, rx_avail_o}, 8'h01);
    chk("R7 status cleared", {7'b0, stat_parity_o}, 8'h00);
    step(0, 0, 0, 1, 0, 8'h00);
    chk("R8 one char stored", {7'b0, rx_avail_o}, 8'h00);
    first_only_i = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule